// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a processor between its run state and five reduced-power states. Software issues a one-cycle entry request that carries a target mode code. The controller then gates the CPU clock, the two PLLs, state retention and the two external supply enables to suit that mode. Each mode has its own way back to run. The two idle modes return on an interrupt. Standby returns on an enabled wake event. The two sleep modes return on an enabled wake event, then wait for the supplies to settle, then pulse a system reset request so that execution restarts from address zero.

The wake sources are 37 general-purpose wake pins and one real-time-clock wake line, each with its own enable. They pass through a two-flop synchronizer. The source that ends a low-power period is recorded in a wake-status vector. A request that cannot be honoured raises an error flag and leaves the controller running.

Mode codes on `req_mode` and `mode_out`: 0 run, 1 idle, 2 deep idle, 3 standby, 4 sleep, 5 deep sleep, 6 supply recovery (reported only on `mode_out`), 7 unused.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `mode_out` is 0 (codes: 0 run, 1 idle, 2 deep idle, 3 standby, 4 sleep, 5 deep sleep, 6 recovery). `cpu_clk_en`, both bits of `pll_en`, `lv_supply_en` and `hv_supply_en` are 1. `retain`, `reset_req`, `req_err` and `wake_src` are 0.
- R2: In run, a request for code 1 enters idle on the next rising edge. Idle has `cpu_clk_en` 0, `pll_en` 2'b11 and both supplies on. `irq` high in idle returns to run on the next rising edge.
- R3: A request for code 2 enters deep idle only when `core_slow` is 1. Deep idle drives the same outputs as idle and returns to run on `irq`.
- R4: A request for code 0, 6 or 7, or for code 2 while `core_slow` is 0, leaves the mode at run and sets `req_err`. The next accepted request clears `req_err`.
- R5: Standby (code 3) has `cpu_clk_en` 0, `pll_en` 2'b00, `retain` 1 and both supplies on. `irq` has no effect in standby. An enabled wake returns it to run with no reset request.
- R6: Sleep (code 4) drives `lv_supply_en` 0 and `hv_supply_en` 1, with `retain` 1 and clocks and PLLs off.
- R7: Deep sleep (code 5) drives both `lv_supply_en` and `hv_supply_en` to 0, with `retain` 1 and clocks and PLLs off.
- R8: A wake input counts only when its enable bit is 1. A wake input that rises before rising edge 1 changes the mode at rising edge 3, not before. A source whose enable bit is 0 leaves the mode unchanged.
- R9: `wake_src` bit i stands for `gpio_wake[i]`, and bit 37 stands for `rtc_wake`. On exit it records the lowest-indexed enabled source that is firing. It holds at most one set bit. It is cleared when standby, sleep or deep sleep is entered.
- R10: A wake from sleep or deep sleep moves to recovery (code 6). Recovery has both supplies on, PLLs off and `retain` 1. After `stab_cycles`+1 cycles in recovery the controller returns to run, and `reset_req` is high for exactly that one cycle.
- R11: Entry requests are ignored in every mode except run. The mode and `req_err` are both left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Entry request strobe |
| req_mode | input | 3 | Requested mode code |
| core_slow | input | 1 | Core clock is at the low oscillator frequency |
| irq | input | 1 | Interrupt, ends the idle modes |
| gpio_wake | input | 37 | Wake pins |
| gpio_wake_en | input | 37 | Per-pin wake enable |
| rtc_wake | input | 1 | Real-time-clock wake |
| rtc_wake_en | input | 1 | Enable for the RTC wake |
| stab_cycles | input | 8 | Supply settling count for sleep exit |
| cpu_clk_en | output | 1 | CPU clock enable |
| pll_en | output | 2 | Core PLL (bit 0) and peripheral PLL (bit 1) enables |
| retain | output | 1 | Retention control for internal domains |
| lv_supply_en | output | 1 | Low-voltage external supply enable |
| hv_supply_en | output | 1 | High-voltage external supply enable |
| reset_req | output | 1 | One-cycle system reset request after a sleep exit |
| wake_src | output | 38 | Latched wake source |
| mode_out | output | 3 | Current mode code |
| req_err | output | 1 | Refused or illegal request flag |

## Verification
A request or an `irq` takes effect at the first rising edge after it is driven, because the mode register is the only register on that path. A wake takes three rising edges: two synchronizer stages and then the mode register. The bench checks that the mode has not changed after the first two edges and has changed after the third. For a sleep exit the bench counts edges until `reset_req` appears and compares the count against `stab_cycles`+4. All inputs change on the falling edge, and every output is sampled on the falling edge that follows the edge on which it is due.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NGPIO  = 37,
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic              core_slow,
  input  logic              irq,
  input  logic [NGPIO-1:0]  gpio_wake,
  input  logic [NGPIO-1:0]  gpio_wake_en,
  input  logic              rtc_wake,
  input  logic              rtc_wake_en,
  input  logic [STAB_W-1:0] stab_cycles,
  output logic              cpu_clk_en,
  output logic [1:0]        pll_en,
  output logic              retain,
  output logic              lv_supply_en,
  output logic              hv_supply_en,
  output logic              reset_req,
  output logic [NGPIO:0]    wake_src,
  output logic [2:0]        mode_out,
  output logic              req_err
);
  localparam int NW = NGPIO + 1;
  localparam logic [2:0] M_RUN = 3'd0, M_IDLE = 3'd1, M_DIDLE = 3'd2, M_STBY = 3'd3,
                         M_SLP = 3'd4, M_DSLP = 3'd5, M_RECOV = 3'd6;

  logic [2:0]        mode_q;
  logic [STAB_W-1:0] cnt_q;
  logic [NW-1:0]     sync1_q, sync2_q, src_q;
  logic              rst_req_q, err_q;

  wire [NW-1:0] hit   = sync2_q & {rtc_wake_en, gpio_wake_en};
  wire [NW-1:0] first = hit & (~hit + {{(NW-1){1'b0}}, 1'b1});
  wire          accept = (req_mode inside {M_IDLE, M_STBY, M_SLP, M_DSLP}) ||
                         (req_mode == M_DIDLE && core_slow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {rtc_wake, gpio_wake};
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_RUN;
      cnt_q     <= '0;
      src_q     <= '0;
      rst_req_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      case (mode_q)
        M_RUN:
          if (req_valid) begin
            if (accept) begin
              mode_q <= req_mode;
              err_q  <= 1'b0;
              if (req_mode >= M_STBY) src_q <= '0;
            end else begin
              err_q <= 1'b1;
            end
          end
        M_IDLE, M_DIDLE:
          if (irq) mode_q <= M_RUN;
        M_STBY:
          if (|hit) begin
            mode_q <= M_RUN;
            src_q  <= first;
          end
        M_SLP, M_DSLP:
          if (|hit) begin
            mode_q <= M_RECOV;
            src_q  <= first;
            cnt_q  <= '0;
          end
        M_RECOV:
          if (cnt_q == stab_cycles) begin
            mode_q    <= M_RUN;
            rst_req_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        default: mode_q <= M_RUN;
      endcase
    end
  end

  assign cpu_clk_en   = (mode_q == M_RUN);
  assign pll_en       = (mode_q inside {M_RUN, M_IDLE, M_DIDLE}) ? 2'b11 : 2'b00;
  assign retain       = (mode_q inside {M_STBY, M_SLP, M_DSLP, M_RECOV});
  assign lv_supply_en = !(mode_q inside {M_SLP, M_DSLP});
  assign hv_supply_en = (mode_q != M_DSLP);
  assign reset_req    = rst_req_q;
  assign wake_src     = src_q;
  assign mode_out     = mode_q;
  assign req_err      = err_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NGPIO = 37
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [2:0]     req_mode,
  input logic           core_slow,
  input logic           irq,
  input logic [1:0]     pll_en,
  input logic           lv_supply_en,
  input logic           hv_supply_en,
  input logic           reset_req,
  input logic [NGPIO:0] wake_src,
  input logic [2:0]     mode_out,
  input logic           req_err
);
  // R2
  idle_irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 3'd1 && irq) |=> mode_out == 3'd0);

  // R3
  deep_idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 3'd2 && $past(mode_out) == 3'd0) |-> $past(core_slow));

  // R4
  refused_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_out == 3'd0 && req_mode == 3'd2 && !core_slow) |=> (mode_out == 3'd0 && req_err));

  // R5
  standby_pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 3'd3) |-> pll_en == 2'b00);

  // R7
  hv_off_only_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_supply_en |-> mode_out == 3'd5);

  // R6
  lv_off_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lv_supply_en |-> (mode_out == 3'd4 || mode_out == 3'd5));

  // R9
  wake_src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_src));

  // R10
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R10
  reset_after_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(mode_out) == 3'd6 && mode_out == 3'd0 && lv_supply_en && hv_supply_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NGPIO(NGPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .core_slow(core_slow), .irq(irq), .pll_en(pll_en), .lv_supply_en(lv_supply_en),
  .hv_supply_en(hv_supply_en), .reset_req(reset_req), .wake_src(wake_src),
  .mode_out(mode_out), .req_err(req_err)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NG = 37;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, core_slow = 1'b0, irq = 1'b0, rtc_wake = 1'b0, rtc_wake_en = 1'b1;
  logic [2:0] req_mode = '0;
  logic [NG-1:0] gpio_wake = '0, gpio_wake_en = '1;
  logic [7:0] stab_cycles = 8'd2;
  logic cpu_clk_en, retain, lv_supply_en, hv_supply_en, reset_req, req_err;
  logic [1:0] pll_en;
  logic [NG:0] wake_src;
  logic [2:0] mode_out;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .core_slow(core_slow), .irq(irq), .gpio_wake(gpio_wake), .gpio_wake_en(gpio_wake_en),
    .rtc_wake(rtc_wake), .rtc_wake_en(rtc_wake_en), .stab_cycles(stab_cycles),
    .cpu_clk_en(cpu_clk_en), .pll_en(pll_en), .retain(retain), .lv_supply_en(lv_supply_en),
    .hv_supply_en(hv_supply_en), .reset_req(reset_req), .wake_src(wake_src),
    .mode_out(mode_out), .req_err(req_err));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [5:0] exp_outs(int m);
    return {m == 0, (m <= 2) ? 2'b11 : 2'b00, m >= 3, !(m == 4 || m == 5), m != 5};
  endfunction

  function automatic logic [5:0] outs();
    return {cpu_clk_en, pll_en, retain, lv_supply_en, hv_supply_en};
  endfunction

  task automatic request(int m);
    req_valid = 1'b1; req_mode = 3'(m);
    step();
    req_valid = 1'b0;
  endtask

  task automatic wake_exit(logic [NG:0] bits, int from, logic [NG:0] exp_src);
    int n;
    {rtc_wake, gpio_wake} = bits;
    step(); step();
    chk("R8 mode held before third edge", mode_out, from);
    step();
    if (from == 3) begin
      chk("R5 standby exit to run", mode_out, 0);
      chk("R5 no reset after standby", reset_req, 0);
    end else begin
      chk("R10 recovery mode", mode_out, 6);
      chk("R10 recovery outputs", outs(), 6'b000111);
      n = 3;
      while (!reset_req && n < 400) begin step(); n++; end
      chk("R10 reset request timing", n, 4 + stab_cycles);
      chk("R10 run with reset", mode_out, 0);
      step();
      chk("R10 reset one cycle", reset_req, 0);
    end
    chk("R9 wake source", wake_src, exp_src);
    {rtc_wake, gpio_wake} = '0;
    step(); step(); step();
  endtask

  task automatic back_home(int m);
    if (m == 1 || m == 2) begin
      irq = 1'b1; step(); irq = 1'b0;
      chk("R2 R3 irq exit", mode_out, 0);
    end else if (m >= 3) begin
      wake_exit(1, m, 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 reset mode", mode_out, 0);
    chk("R1 reset outputs", outs(), 6'b111011);
    chk("R1 reset flags", {reset_req, req_err, wake_src}, 0);

    for (int slow = 0; slow < 2; slow++) begin
      for (int c = 0; c < 8; c++) begin
        logic acc;
        acc = (c >= 1 && c <= 5) && !(c == 2 && !slow);
        core_slow = slow[0];
        request(c);
        chk("R4 accept or refuse", mode_out, acc ? c : 0);
        chk("R4 error flag", req_err, !acc);
        chk("R2 R3 R5 R6 R7 mode outputs", outs(), exp_outs(acc ? c : 0));
        back_home(acc ? c : 0);
      end
    end

    request(1);
    request(3);
    chk("R11 request ignored in idle", mode_out, 1);
    chk("R11 error unchanged", req_err, 0);
    back_home(1);

    request(3);
    irq = 1'b1; step(); step(); step(); irq = 1'b0;
    chk("R5 irq ignored in standby", mode_out, 3);
    back_home(3);

    for (int i = 0; i <= NG; i++) begin
      request(3);
      chk("R9 cleared on entry", wake_src, 0);
      wake_exit((NG+1)'(1) << i, 3, (NG+1)'(1) << i);
    end

    request(3);
    {rtc_wake_en, gpio_wake_en} = (NG+1)'(1);
    gpio_wake[7] = 1'b1; rtc_wake = 1'b1;
    step(); step(); step(); step();
    chk("R8 disabled wake ignored", mode_out, 3);
    {rtc_wake, gpio_wake} = '0;
    step(); step();
    {rtc_wake_en, gpio_wake_en} = '1;
    wake_exit(1, 3, 1);

    request(3);
    wake_exit((NG+1)'(1) << NG | (NG+1)'(1) << 20 | (NG+1)'(1) << 5, 3, (NG+1)'(1) << 5);

    for (int s = 0; s < 4; s++) begin
      stab_cycles = (s == 3) ? 8'd9 : 8'(s);
      request(4);
      chk("R6 sleep supplies", {lv_supply_en, hv_supply_en}, 2'b01);
      wake_exit((NG+1)'(1) << (s + 3), 4, (NG+1)'(1) << (s + 3));
      request(5);
      chk("R7 deep sleep supplies", {lv_supply_en, hv_supply_en}, 2'b00);
      wake_exit((NG+1)'(1) << NG, 5, (NG+1)'(1) << NG);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule